// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Flagged Receive Queue

This block recovers asynchronous serial characters from a single input line. The line is sampled on a 16x baud enable supplied from outside. A falling edge starts a character, and a sample taken half a bit later confirms it. Eight data bits then arrive least significant bit first. An optional parity bit follows, and then one or two stop bits. Each finished character goes into a 16-entry first-in first-out queue. The host drains the queue through a pop strobe.

A single sticky error bit records three kinds of error:

- **Stop-bit error:** the first stop bit is sampled as 0.
- **Parity mismatch:** the data and parity bits disagree with the selected parity.
- **Overflow:** a character finishes while the queue is full.

A character with a stop-bit error or a parity mismatch is still queued. A configuration input then decides whether reception pauses. An overflowing character is discarded, and reception always pauses. Once paused, the receiver stays idle until the error bit is cleared. Software clears the error bit in two steps: it must first read the bit as 1, then write 0 to it.

Top module: `serial_rx_errfifo`

## Requirements
- R1: With parity off and one stop bit, a frame is a start bit (0), eight data bits least significant first, then a stop bit (1). The eight data bits are queued and appear on `rx_data_o` in arrival order.
- R2: With `par_en_i`=1, one parity bit follows the data. `par_odd_i`=0 expects an even total count of ones over data plus parity, and `par_odd_i`=1 expects an odd count. On a mismatch the error bit is set and the character is still queued.
- R3: If the first stop bit is sampled as 0, the error bit is set and the character is still queued.
- R4: With `two_stop_i`=1, the value of the second stop bit has no effect on the error bit or on the queued data.
- R5: A character that finishes while the queue holds 16 entries is discarded, sets the error bit, and pauses reception until the error bit is cleared.
- R6: After a stop-bit or parity error, `halt_on_err_i`=1 pauses reception until the error bit is cleared. `halt_on_err_i`=0 lets reception continue.
- R7: The error bit clears only on a write strobe with data 0 that follows a read strobe which saw it at 1. A write of 0 without such a read, or a write of 1, leaves it at 1. A new error cancels an earlier read.
- R8: While `rx_en_i`=0, no character is received and the error bit keeps its value.
- R9: After reset the error bit is 0 and the queue is empty.
- R10: The queue holds 16 characters, and `rx_full_o` is 1 exactly when it does. A pop while the queue is empty has no effect.
- R11: A low pulse on the line shorter than half a bit period is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high |
| baud_tick_i | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_en_i | input | 1 | Receive enable |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop_i | input | 1 | 1 selects two stop bits |
| halt_on_err_i | input | 1 | Pause reception after a stop-bit or parity error |
| pop_i | input | 1 | Remove the head entry of the queue |
| rx_data_o | output | 8 | Head entry of the queue |
| rx_avail_o | output | 1 | Queue not empty |
| rx_full_o | output | 1 | Queue holds 16 entries |
| flag_rd_i | input | 1 | Read strobe for the error bit |
| flag_wr_i | input | 1 | Write strobe for the error bit |
| flag_wdata_i | input | 1 | Value written to the error bit |
| err_flag_o | output | 1 | Sticky receive error bit |

## Verification
A wrong sampling phase or an off-by-one bit counter shows up as corrupted or shifted data on the very next popped character. A sweep of all 256 byte values exposes it within one frame. A faulty parity or stop-bit decision shows on `err_flag_o` one cycle after the character completes. A stuck pause or a stuck clear-enable shows as a missing character, or as a bit that refuses to clear, on the next frame or write.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_t;
endpackage

// File: rtl/srx_bitengine.sv
module srx_bitengine
  import srx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int CW = $clog2(TICKS_PER_BIT);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] MID_CNT  = CW'(TICKS_PER_BIT/2 - 1);
  localparam logic [CW-1:0] TOP_CNT  = CW'(TICKS_PER_BIT - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  rx_state_t         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              prev_q, prev_d;
  logic              perr_q, perr_d;
  logic              ferr_q, ferr_d;
  logic              done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    done_d  = 1'b0;
    prev_d  = tick_i ? line_i : prev_q;
    if (!run_i) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
    end else if (tick_i) begin
      unique case (state_q)
        RX_IDLE: begin
          if (prev_q && !line_i) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_d = '0;
            if (!line_i) begin
              state_d = RX_DATA;
              bit_d   = '0;
              perr_d  = 1'b0;
              ferr_d  = 1'b0;
            end else begin
              state_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == TOP_CNT) begin
            cnt_d   = '0;
            shift_d = {line_i, shift_q[DATA_W-1:1]};
            if (bit_q == LAST_BIT) begin
              state_d = par_en_i ? RX_PAR : RX_STOP1;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt_q == TOP_CNT) begin
            cnt_d   = '0;
            perr_d  = ((^shift_q) ^ line_i) != par_odd_i;
            state_d = RX_STOP1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP1: begin
          if (cnt_q == TOP_CNT) begin
            cnt_d  = '0;
            ferr_d = !line_i;
            if (two_stop_i) begin
              state_d = RX_STOP2;
            end else begin
              state_d = RX_IDLE;
              done_d  = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP2: begin
          if (cnt_q == TOP_CNT) begin
            cnt_d   = '0;
            state_d = RX_IDLE;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      prev_q  <= 1'b1;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      prev_q  <= prev_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;
  assign data_o = shift_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              avail_o,
  output logic              full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW:0]       wptr_q, wptr_d, rptr_q, rptr_d;
  logic              empty, full, wr_en, rd_en;

  assign empty = (wptr_q == rptr_q);
  assign full  = (wptr_q[AW-1:0] == rptr_q[AW-1:0]) && (wptr_q[AW] != rptr_q[AW]);
  assign wr_en = push_i && !full;
  assign rd_en = pop_i && !empty;

  always_comb begin
    wptr_d = wr_en ? wptr_q + 1'b1 : wptr_q;
    rptr_d = rd_en ? rptr_q + 1'b1 : rptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wptr_q[AW-1:0]] <= din_i;
    end
  end

  assign dout_o  = mem_q[rptr_q[AW-1:0]];
  assign avail_o = !empty;
  assign full_o  = full;
endmodule

// File: rtl/srx_errflag.sv
module srx_errflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (rd_i && flag_q) begin
      armed_d = 1'b1;
    end
    if (wr_i && !wdata_i && armed_q) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (set_i) begin
      flag_d  = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/serial_rx_errfifo.sv
module serial_rx_errfifo #(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              baud_tick_i,
  input  logic              rx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              halt_on_err_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_avail_o,
  output logic              rx_full_o,
  input  logic              flag_rd_i,
  input  logic              flag_wr_i,
  input  logic              flag_wdata_i,
  output logic              err_flag_o
);
  logic [1:0]             rst_sync_q;
  logic                   rst_q;
  logic [SYNC_STAGES-1:0] line_sync_q;
  logic                   line;
  logic                   halt_q, halt_d, halt_set;
  logic                   run, char_done, chr_perr, chr_ferr;
  logic [DATA_W-1:0]      chr_data;
  logic                   push, overrun, err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      line_sync_q <= '1;
    end else begin
      line_sync_q <= {line_sync_q[SYNC_STAGES-2:0], rxd_i};
    end
  end
  assign line = line_sync_q[SYNC_STAGES-1];

  assign run = rx_en_i && !halt_q;

  srx_bitengine #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DATA_W       (DATA_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_q),
    .run_i     (run),
    .tick_i    (baud_tick_i),
    .line_i    (line),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .two_stop_i(two_stop_i),
    .done_o    (char_done),
    .data_o    (chr_data),
    .perr_o    (chr_perr),
    .ferr_o    (chr_ferr)
  );

  assign overrun  = char_done && rx_full_o;
  assign push     = char_done && !rx_full_o;
  assign err_set  = char_done && (rx_full_o || chr_perr || chr_ferr);
  assign halt_set = overrun || (char_done && (chr_perr || chr_ferr) && halt_on_err_i);

  srx_fifo #(
    .DATA_W(DATA_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk    (clk),
    .rst_n  (rst_q),
    .push_i (push),
    .din_i  (chr_data),
    .pop_i  (pop_i),
    .dout_o (rx_data_o),
    .avail_o(rx_avail_o),
    .full_o (rx_full_o)
  );

  srx_errflag u_flag (
    .clk    (clk),
    .rst_n  (rst_q),
    .set_i  (err_set),
    .rd_i   (flag_rd_i),
    .wr_i   (flag_wr_i),
    .wdata_i(flag_wdata_i),
    .flag_o (err_flag_o)
  );

  always_comb begin
    if (halt_set) begin
      halt_d = 1'b1;
    end else if (!err_flag_o) begin
      halt_d = 1'b0;
    end else begin
      halt_d = halt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      halt_q <= 1'b0;
    end else begin
      halt_q <= halt_d;
    end
  end
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic pop,
  input logic flag_wr,
  input logic flag_wdata,
  input logic char_done,
  input logic chr_perr,
  input logic rx_avail,
  input logic rx_full,
  input logic err_flag
);
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(flag_wr && !flag_wdata)) |=> err_flag);

  // R5
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_full) |=> err_flag);

  // R5
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_full && !pop) |=> rx_full);

  // R2
  perr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && chr_perr) |=> err_flag);

  // R10
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_avail && !char_done) |=> !rx_avail);

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && $past(!rx_en)) |-> !char_done);

  // R8
  off_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !char_done && !(flag_wr && !flag_wdata)) |=> (err_flag == $past(err_flag)));
endmodule

bind serial_rx_errfifo srx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .rx_en     (rx_en_i),
  .pop       (pop_i),
  .flag_wr   (flag_wr_i),
  .flag_wdata(flag_wdata_i),
  .char_done (char_done),
  .chr_perr  (chr_perr),
  .rx_avail  (rx_avail_o),
  .rx_full   (rx_full_o),
  .err_flag  (err_flag_o)
);

// File: tb/sim_serial_rx_errfifo.sv
`timescale 1ns/1ps
module sim_serial_rx_errfifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic       rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, halt_on_err = 1'b0;
  logic       pop = 1'b0, flag_rd = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic [7:0] rx_data;
  logic       rx_avail, rx_full, err_flag;
  int         checks = 0;
  int         failures = 0;

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  serial_rx_errfifo u0 (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .baud_tick_i(tick), .rx_en_i(rx_en),
    .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop),
    .halt_on_err_i(halt_on_err), .pop_i(pop), .rx_data_o(rx_data),
    .rx_avail_o(rx_avail), .rx_full_o(rx_full), .flag_rd_i(flag_rd),
    .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata), .err_flag_o(err_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (32) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic stop1, input logic stop2);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (par_en) drive_bit((^d) ^ par_odd ^ bad_par);
    drive_bit(stop1);
    if (two_stop) drive_bit(stop2);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  task automatic expect_char(input string req, input logic [7:0] d);
    chk({req, " avail"}, int'(rx_avail), 1);
    chk({req, " data"}, int'(rx_data), int'(d));
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_empty(input string req);
    chk({req, " empty"}, int'(rx_avail), 0);
  endtask

  task automatic strobe_rd();
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic strobe_wr(input logic v);
    flag_wdata = v;
    flag_wr = 1'b1;
    @(negedge clk);
    flag_wr = 1'b0;
    flag_wdata = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_flag();
    strobe_rd();
    strobe_wr(1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R9: reset state
    chk("R9 flag", int'(err_flag), 0);
    chk("R9 avail", int'(rx_avail), 0);
    chk("R9 full", int'(rx_full), 0);
    rx_en = 1'b1;

    // R1: every byte value, no parity, one stop bit
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b0, 1'b1, 1'b1);
      expect_char("R1", 8'(v));
    end
    chk("R1 flag", int'(err_flag), 0);

    // R2/R4: good parity under all parity and stop settings
    for (int cfg = 0; cfg < 4; cfg++) begin
      par_en = 1'b1;
      par_odd = cfg[0];
      two_stop = cfg[1];
      for (int k = 0; k < 6; k++) begin
        logic [7:0] d;
        d = 8'((k * 73 + cfg * 29 + 5) & 255);
        send(d, 1'b0, 1'b1, 1'b0);
        expect_char("R2 R4 good", d);
      end
      chk("R2 R4 no error", int'(err_flag), 0);
    end

    // R2/R6: parity mismatch, continue mode
    two_stop = 1'b0;
    halt_on_err = 1'b0;
    par_odd = 1'b0;
    send(8'hA5, 1'b1, 1'b1, 1'b1);
    chk("R2 even mismatch flag", int'(err_flag), 1);
    expect_char("R2 stored", 8'hA5);
    send(8'h3C, 1'b0, 1'b1, 1'b1);
    expect_char("R6 continues", 8'h3C);
    clear_flag();
    chk("R7 cleared", int'(err_flag), 0);
    par_odd = 1'b1;
    send(8'h0F, 1'b1, 1'b1, 1'b1);
    chk("R2 odd mismatch flag", int'(err_flag), 1);
    expect_char("R2 odd stored", 8'h0F);
    clear_flag();
    par_en = 1'b0;

    // R3: framing error, data kept
    send(8'h81, 1'b0, 1'b0, 1'b1);
    chk("R3 flag", int'(err_flag), 1);
    expect_char("R3 stored", 8'h81);

    // R7: write 0 without read, write 1 after read
    strobe_wr(1'b0);
    chk("R7 no read", int'(err_flag), 1);
    strobe_rd();
    strobe_wr(1'b1);
    chk("R7 write one", int'(err_flag), 1);
    strobe_wr(1'b0);
    chk("R7 read then zero", int'(err_flag), 0);
    strobe_rd();
    send(8'h22, 1'b0, 1'b0, 1'b1);
    expect_char("R7 setup", 8'h22);
    strobe_wr(1'b0);
    chk("R7 read of zero does not arm", int'(err_flag), 1);
    strobe_rd();
    send(8'h44, 1'b0, 1'b0, 1'b1);
    expect_char("R7 setup2", 8'h44);
    strobe_wr(1'b0);
    chk("R7 new error cancels read", int'(err_flag), 1);
    clear_flag();
    chk("R7 final clear", int'(err_flag), 0);

    // R4: second stop bit low is ignored
    two_stop = 1'b1;
    send(8'h96, 1'b0, 1'b1, 1'b0);
    chk("R4 flag", int'(err_flag), 0);
    expect_char("R4 data", 8'h96);
    two_stop = 1'b0;

    // R6: halt mode
    halt_on_err = 1'b1;
    send(8'h11, 1'b0, 1'b0, 1'b1);
    chk("R6 flag", int'(err_flag), 1);
    send(8'h12, 1'b0, 1'b1, 1'b1);
    expect_char("R6 error char", 8'h11);
    expect_empty("R6 halted");
    clear_flag();
    send(8'h13, 1'b0, 1'b1, 1'b1);
    expect_char("R6 resumed", 8'h13);
    halt_on_err = 1'b0;

    // R10/R5: fill, then overflow
    for (int i = 0; i < 16; i++) begin
      chk("R10 not full yet", int'(rx_full), 0);
      send(8'(i + 8'h60), 1'b0, 1'b1, 1'b1);
    end
    chk("R10 full", int'(rx_full), 1);
    chk("R10 no flag", int'(err_flag), 0);
    send(8'hEE, 1'b0, 1'b1, 1'b1);
    chk("R5 flag", int'(err_flag), 1);
    for (int i = 0; i < 16; i++) expect_char("R5 kept", 8'(i + 8'h60));
    expect_empty("R5 dropped");
    send(8'h77, 1'b0, 1'b1, 1'b1);
    expect_empty("R5 stopped");
    clear_flag();
    send(8'h78, 1'b0, 1'b1, 1'b1);
    expect_char("R5 resumed", 8'h78);

    // R8: receive disabled
    send(8'h01, 1'b0, 1'b0, 1'b1);
    expect_char("R8 setup", 8'h01);
    rx_en = 1'b0;
    send(8'h55, 1'b0, 1'b0, 1'b1);
    expect_empty("R8 off no data");
    chk("R8 flag kept 1", int'(err_flag), 1);
    clear_flag();
    send(8'h56, 1'b0, 1'b0, 1'b1);
    chk("R8 flag kept 0", int'(err_flag), 0);
    expect_empty("R8 off no data2");
    rx_en = 1'b1;

    // R11: short glitch
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    expect_empty("R11 glitch");
    chk("R11 flag", int'(err_flag), 0);

    // R10: pop on empty ignored
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
    expect_empty("R10 pop empty");
    send(8'hC3, 1'b0, 1'b1, 1'b1);
    expect_char("R10 after empty pop", 8'hC3);
    expect_empty("R10 drained");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule